// File: doc/BRIEF.md
# Isochronous Transaction Record Executor

This block takes one high-speed isochronous transfer descriptor that upstream logic has already fetched. The descriptor carries eight transaction records, an array of buffer page pointers and the endpoint settings. Using the current micro-frame number, the block picks one record. If that record is armed, the block issues one transaction request to the data mover: a buffer start address, a byte count, a direction and the device/endpoint token fields. When the data mover reports completion, the block emits the updated record once, so it can be stored back in memory.

Each transaction record is one 32-bit word. From bit 31 down it holds: active [31], buffer error [30], babble [29], transaction error [28], remaining length [27:16], completion-interrupt flag [15], page select [14:12] and page offset [11:0]. Each page pointer gives address bits [31:12] of a 4 KB aligned page. The result code from the data mover uses these values: 0 success, 1 buffer fault, 2 babble, 3 transaction fault.

The descriptor input, the request output and the completion input each use a valid/ready handshake. The write-back is a single-cycle strobe that carries the record and its slot number.

Top module: `iso_rec_exec`

## Requirements
- R1: While reset is held, and in the first cycle after it, the block is ready for a descriptor and drives no request valid, no completion ready and no write-back strobe.
- R2: The micro-frame number `desc_uframe` [2:0] selects which record is used; for example, value 2 selects record 2. The slot of that record appears on `wb_slot` with the write-back.
- R3: If bit 31 (active) of the selected record is zero, the block issues no request and no write-back, and it is ready again in the cycle after the descriptor was taken.
- R4: The request address is the 20-bit page pointer chosen by the record's page field [14:12], followed by the record's 12-bit offset [11:0] as the low bits.
- R5: The request carries the descriptor's device address, endpoint number and direction bit without change.
- R6: The request length is the smaller of the record's length field [27:16] and the endpoint's 11-bit maximum packet size.
- R7: While the request is valid and not accepted, the request stays valid and all of its fields stay unchanged.
- R8: The length field of the written-back record equals the old length minus the byte count the data mover reported.
- R9: In the written-back record, active is cleared. Result code 1 sets bit 30, code 2 sets bit 29 and code 3 sets bit 28. Error bits that were already set stay set. Bits [15:0] are unchanged.
- R10: The cycle after a completion is accepted, `wb_valid` is high for exactly one cycle. In the cycle after that, the block is ready for the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and taking a descriptor |
| desc_recs | input | 256 | Eight records; record n sits in bits [32n+31:32n] |
| desc_pages | input | 160 | Eight page pointers; pointer n sits in bits [20n+19:20n] |
| desc_dev | input | 7 | Device address |
| desc_ep | input | 4 | Endpoint number |
| desc_dir | input | 1 | Direction bit (1 = IN) |
| desc_mps | input | 11 | Maximum packet size in bytes |
| desc_uframe | input | 3 | Current micro-frame number |
| req_valid | output | 1 | Transaction request offered |
| req_ready | input | 1 | Data mover takes the request |
| req_addr | output | 32 | Buffer start address |
| req_len | output | 12 | Transaction byte count |
| req_dir | output | 1 | Transaction direction |
| req_dev | output | 7 | Token device address |
| req_ep | output | 4 | Token endpoint number |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Block waiting for completion |
| cmp_bytes | input | 12 | Bytes actually moved |
| cmp_code | input | 2 | Result code |
| wb_valid | output | 1 | Updated record strobe |
| wb_slot | output | 3 | Record slot being written back |
| wb_rec | output | 32 | Updated record |

## Verification
The assertions assume two things about the inputs. First, the data mover never reports more bytes than the request asked for. Second, the maximum packet size is never larger than the record-length range can hold. Under these assumptions, the new length can never underflow and the issued length can never exceed either bound. In the stimulus, the reported byte count is always the issued length minus a small amount, floored at zero. The packet sizes used are at most 1024. Handshake inputs are changed only between clock edges, and a valid input is held until it is accepted.

// File: rtl/iso_rec_pkg.sv
// Shared layout of one transaction record, result codes and control states.
// Assumes 32-bit records and 4 KB pages; field positions are fixed because
// the memory image of the descriptor depends on them.
package iso_rec_pkg;
    localparam int NREC   = 8;
    localparam int IDX_W  = $clog2(NREC);
    localparam int PG_W   = 3;
    localparam int NPAGE  = 1 << PG_W;
    localparam int OFF_W  = 12;
    localparam int PTR_W  = 20;
    localparam int ADDR_W = PTR_W + OFF_W;
    localparam int LEN_W  = 12;
    localparam int MPS_W  = 11;
    localparam int DEV_W  = 7;
    localparam int EP_W   = 4;
    localparam int CODE_W = 2;
    localparam int REC_W  = 4 + LEN_W + 1 + PG_W + OFF_W;

    typedef struct packed {
        logic             active;
        logic             err_buf;
        logic             err_babble;
        logic             err_xact;
        logic [LEN_W-1:0] len;
        logic             ioc;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] offset;
    } xrec_t;

    typedef enum logic [CODE_W-1:0] {
        RES_OK     = 2'd0,
        RES_BUF    = 2'd1,
        RES_BABBLE = 2'd2,
        RES_XACT   = 2'd3
    } res_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } st_t;
endpackage

// File: rtl/iso_rec_pick.sv
// Selects one record from the flat descriptor by micro-frame index and the
// page pointer addressed by that record's page field.
// Assumes the flat buses pack entry n at the n-th slice from bit 0.
module iso_rec_pick
    import iso_rec_pkg::*;
#(
    parameter int N_REC  = NREC,
    parameter int N_PAGE = NPAGE,
    localparam int SEL_W = $clog2(N_REC)
) (
    input  logic [N_REC*REC_W-1:0]  recs,
    input  logic [N_PAGE*PTR_W-1:0] pages,
    input  logic [SEL_W-1:0]        idx,
    output xrec_t                   rec,
    output logic [PTR_W-1:0]        ptr
);
    xrec_t            rec_arr [N_REC];
    logic [PTR_W-1:0] ptr_arr [N_PAGE];

    // Unpack record slices into an array.
    for (genvar gi = 0; gi < N_REC; gi++) begin : g_rec
        assign rec_arr[gi] = recs[gi*REC_W +: REC_W];
    end

    // Unpack page pointer slices into an array.
    for (genvar gp = 0; gp < N_PAGE; gp++) begin : g_pg
        assign ptr_arr[gp] = pages[gp*PTR_W +: PTR_W];
    end

    // Index the record by micro-frame, then the pointer by its page field.
    always_comb begin
        rec = rec_arr[idx];
        ptr = ptr_arr[rec.page];
    end
endmodule

// File: rtl/iso_xact_calc.sv
// Forms the buffer start address and the transaction byte count of a record.
// Assumes the packet size fits the record length width.
module iso_xact_calc
    import iso_rec_pkg::*;
(
    input  xrec_t              rec,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [MPS_W-1:0]   mps,
    output logic [ADDR_W-1:0]  addr,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0] mps_ext;

    // Join page pointer with offset and clip length to the packet size.
    always_comb begin
        mps_ext = LEN_W'(mps);
        addr    = {ptr, rec.offset};
        len     = (rec.len < mps_ext) ? rec.len : mps_ext;
    end
endmodule

// File: rtl/iso_rec_update.sv
// Builds the record image to write back after a transaction: length reduced
// by bytes moved, active cleared, error flag set from the result code.
// Assumes bytes moved never exceed the record length.
module iso_rec_update
    import iso_rec_pkg::*;
(
    input  xrec_t              rec_in,
    input  logic [LEN_W-1:0]   bytes,
    input  logic [CODE_W-1:0]  code,
    output xrec_t              rec_out
);
    // Merge the completion result into the record.
    always_comb begin
        rec_out            = rec_in;
        rec_out.active     = 1'b0;
        rec_out.len        = rec_in.len - bytes;
        rec_out.err_buf    = rec_in.err_buf    | (res_t'(code) == RES_BUF);
        rec_out.err_babble = rec_in.err_babble | (res_t'(code) == RES_BABBLE);
        rec_out.err_xact   = rec_in.err_xact   | (res_t'(code) == RES_XACT);
    end
endmodule

// File: rtl/iso_rec_exec.sv
// Executes one micro-frame's transaction from a fetched isochronous
// descriptor: accept descriptor, skip if the chosen record is idle, else
// issue one request, wait for its completion and strobe one write-back.
// Assumes inputs are held while their valid is high and that the reported
// byte count never exceeds the issued length.
module iso_rec_exec
    import iso_rec_pkg::*;
#(
    parameter int N_REC  = NREC,
    parameter int N_PAGE = NPAGE,
    localparam int SEL_W = $clog2(N_REC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    desc_valid,
    output logic                    desc_ready,
    input  logic [N_REC*REC_W-1:0]  desc_recs,
    input  logic [N_PAGE*PTR_W-1:0] desc_pages,
    input  logic [DEV_W-1:0]        desc_dev,
    input  logic [EP_W-1:0]         desc_ep,
    input  logic                    desc_dir,
    input  logic [MPS_W-1:0]        desc_mps,
    input  logic [SEL_W-1:0]        desc_uframe,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [LEN_W-1:0]        req_len,
    output logic                    req_dir,
    output logic [DEV_W-1:0]        req_dev,
    output logic [EP_W-1:0]         req_ep,
    input  logic                    cmp_valid,
    output logic                    cmp_ready,
    input  logic [LEN_W-1:0]        cmp_bytes,
    input  logic [CODE_W-1:0]       cmp_code,
    output logic                    wb_valid,
    output logic [SEL_W-1:0]        wb_slot,
    output logic [REC_W-1:0]        wb_rec
);
    st_t              st;
    xrec_t            pick_rec, rec_q, upd_rec, wb_q;
    logic [PTR_W-1:0] pick_ptr, ptr_q;
    logic [SEL_W-1:0] slot_q;
    logic [DEV_W-1:0] dev_q;
    logic [EP_W-1:0]  ep_q;
    logic             dir_q;
    logic [MPS_W-1:0] mps_q;

    iso_rec_pick #(.N_REC(N_REC), .N_PAGE(N_PAGE)) u_pick (
        .recs  (desc_recs),
        .pages (desc_pages),
        .idx   (desc_uframe),
        .rec   (pick_rec),
        .ptr   (pick_ptr)
    );

    iso_xact_calc u_calc (
        .rec  (rec_q),
        .ptr  (ptr_q),
        .mps  (mps_q),
        .addr (req_addr),
        .len  (req_len)
    );

    iso_rec_update u_upd (
        .rec_in  (rec_q),
        .bytes   (cmp_bytes),
        .code    (cmp_code),
        .rec_out (upd_rec)
    );

    // Sequence idle -> request -> wait -> write-back, skipping idle records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (desc_valid) st <= pick_rec.active ? ST_REQ : ST_IDLE;
                ST_REQ:  if (req_ready)  st <= ST_WAIT;
                ST_WAIT: if (cmp_valid)  st <= ST_WB;
                ST_WB:   st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture the chosen record and endpoint settings at descriptor accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q  <= '0;
            ptr_q  <= '0;
            slot_q <= '0;
            dev_q  <= '0;
            ep_q   <= '0;
            dir_q  <= 1'b0;
            mps_q  <= '0;
        end else if (st == ST_IDLE && desc_valid) begin
            rec_q  <= pick_rec;
            ptr_q  <= pick_ptr;
            slot_q <= desc_uframe;
            dev_q  <= desc_dev;
            ep_q   <= desc_ep;
            dir_q  <= desc_dir;
            mps_q  <= desc_mps;
        end
    end

    // Register the updated record when the completion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else if (st == ST_WAIT && cmp_valid) begin
            wb_q <= upd_rec;
        end
    end

    // Drive handshake and token outputs from state and captured fields.
    always_comb begin
        desc_ready = (st == ST_IDLE);
        req_valid  = (st == ST_REQ);
        cmp_ready  = (st == ST_WAIT);
        wb_valid   = (st == ST_WB);
        wb_slot    = slot_q;
        wb_rec     = wb_q;
        req_dir    = dir_q;
        req_dev    = dev_q;
        req_ep     = ep_q;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> desc_ready && !req_valid && !cmp_ready && !wb_valid); // R1
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_ready, req_valid, cmp_ready, wb_valid})); // R1
    AST_SKIP_IDLE_REC: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready && !desc_recs[desc_uframe*REC_W + REC_W - 1]
        |=> desc_ready); // R3
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len <= LEN_W'(mps_q)) && (req_len <= rec_q.len)); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
        && $stable(req_len) && $stable(req_dev) && $stable(req_ep) && $stable(req_dir)); // R7
    AST_CMP_BYTES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |-> cmp_bytes <= req_len); // R8
    AST_WB_LEN_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_q.len <= rec_q.len); // R8
    AST_WB_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !wb_rec[REC_W-1]); // R9
    AST_WB_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_rec[REC_W-2 -: 3] & {rec_q.err_buf, rec_q.err_babble, rec_q.err_xact})
        == {rec_q.err_buf, rec_q.err_babble, rec_q.err_xact}); // R9
    AST_WB_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> wb_valid); // R10
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid && desc_ready); // R10
endmodule

// File: tb/sim_iso_rec_exec.sv
`timescale 1ns/1ps
module sim_iso_rec_exec;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         desc_valid;
    logic         desc_ready;
    logic [255:0] desc_recs;
    logic [159:0] desc_pages;
    logic [6:0]   desc_dev;
    logic [3:0]   desc_ep;
    logic         desc_dir;
    logic [10:0]  desc_mps;
    logic [2:0]   desc_uframe;
    logic         req_valid, req_ready;
    logic [31:0]  req_addr;
    logic [11:0]  req_len;
    logic         req_dir;
    logic [6:0]   req_dev;
    logic [3:0]   req_ep;
    logic         cmp_valid, cmp_ready;
    logic [11:0]  cmp_bytes;
    logic [1:0]   cmp_code;
    logic         wb_valid;
    logic [2:0]   wb_slot;
    logic [31:0]  wb_rec;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    iso_rec_exec u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int uf, input int k);
        int mps, len, page, off, bytes, code, elen, stall;
        logic active, ioc, prev_x;
        logic [31:0] sel, exp_wb, exp_addr;
        logic [19:0] pg;
        case (k)
            0: begin mps = 512;  len = 100;  end
            1: begin mps = 64;   len = 50;   end
            2: begin mps = 1024; len = 3000; end
            3: begin mps = 300;  len = 0;    end
            4: begin mps = 1024; len = 1024; end
            default: begin mps = 200; len = 700; end
        endcase
        active = (k != 1);
        ioc    = k[0];
        page   = (uf + k) % 8;
        off    = (uf * 291 + k * 69) % 4096;
        prev_x = (k == 5);
        sel    = {active, 1'b0, 1'b0, prev_x, 12'(len), ioc, 3'(page), 12'(off)};
        for (int s = 0; s < 8; s++) begin
            desc_recs[s*32 +: 32] = (s == uf) ? sel
                : {4'b1000, 12'(s * 37 + 5), 1'b0, 3'(s), 12'(s * 100 + uf)};
            desc_pages[s*20 +: 20] = 20'h40000 + 20'(s) * 20'h01111 + 20'(uf);
        end
        desc_dev    = 7'(uf * 13 + k);
        desc_ep     = 4'(uf + k * 3);
        desc_dir    = 1'((uf + k) % 2);
        desc_mps    = 11'(mps);
        desc_uframe = 3'(uf);
        pg       = desc_pages[page*20 +: 20];
        exp_addr = {pg, 12'(off)};
        elen     = (len < mps) ? len : mps;
        bytes    = (elen >= k) ? elen - k : 0;
        code     = (uf + k) % 4;
        exp_wb   = {1'b0, code == 1, code == 2, (code == 3) || prev_x,
                    12'(len - bytes), ioc, 3'(page), 12'(off)};
        chk("R10", "desc_ready before offer", {31'd0, desc_ready}, 32'd1);
        desc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        if (!active) begin
            for (int c = 0; c < 3; c++) begin
                chk("R3", "req_valid idle record", {31'd0, req_valid}, 32'd0);
                chk("R3", "wb_valid idle record", {31'd0, wb_valid}, 32'd0);
                chk("R3", "desc_ready idle record", {31'd0, desc_ready}, 32'd1);
                @(negedge clk);
            end
            return;
        end
        chk("R2", "req_valid active record", {31'd0, req_valid}, 32'd1);
        chk("R4", "req_addr", req_addr, exp_addr);
        chk("R6", "req_len", {20'd0, req_len}, 32'(elen));
        chk("R5", "req_dev", {25'd0, req_dev}, {25'd0, desc_dev});
        chk("R5", "req_ep", {28'd0, req_ep}, {28'd0, desc_ep});
        chk("R5", "req_dir", {31'd0, req_dir}, {31'd0, desc_dir});
        stall = k % 3;
        for (int c = 0; c < stall; c++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7", "req_valid held", {31'd0, req_valid}, 32'd1);
            chk("R7", "req_addr held", req_addr, exp_addr);
            chk("R7", "req_len held", {20'd0, req_len}, 32'(elen));
        end
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        chk("R7", "req_valid dropped after accept", {31'd0, req_valid}, 32'd0);
        chk("R10", "cmp_ready", {31'd0, cmp_ready}, 32'd1);
        if (uf % 2 == 1) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10", "no early write-back", {31'd0, wb_valid}, 32'd0);
        end
        cmp_valid = 1'b1;
        cmp_bytes = 12'(bytes);
        cmp_code  = 2'(code);
        @(posedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk("R10", "wb_valid after completion", {31'd0, wb_valid}, 32'd1);
        chk("R2", "wb_slot", {29'd0, wb_slot}, 32'(uf));
        chk("R8", "wb length", {20'd0, wb_rec[27:16]}, {20'd0, exp_wb[27:16]});
        chk("R9", "wb status", {28'd0, wb_rec[31:28]}, {28'd0, exp_wb[31:28]});
        chk("R9", "wb low bits", {16'd0, wb_rec[15:0]}, {16'd0, exp_wb[15:0]});
        @(posedge clk);
        @(negedge clk);
        chk("R10", "wb_valid single cycle", {31'd0, wb_valid}, 32'd0);
        chk("R10", "desc_ready after write-back", {31'd0, desc_ready}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        desc_valid = 1'b0; desc_recs = '0; desc_pages = '0;
        desc_dev = '0; desc_ep = '0; desc_dir = 1'b0; desc_mps = '0; desc_uframe = '0;
        req_ready = 1'b0; cmp_valid = 1'b0; cmp_bytes = '0; cmp_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "desc_ready in reset", {31'd0, desc_ready}, 32'd1);
        chk("R1", "req_valid in reset", {31'd0, req_valid}, 32'd0);
        chk("R1", "cmp_ready in reset", {31'd0, cmp_ready}, 32'd0);
        chk("R1", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "desc_ready after reset", {31'd0, desc_ready}, 32'd1);
        for (int uf = 0; uf < 8; uf++) begin
            for (int k = 0; k < 6; k++) begin
                run_case(uf, k);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule